// File: doc/BRIEF.md
# Tile-triggered pattern bank latch

This block sits on the video-side address bus and turns pattern-space addresses into pattern-ROM addresses. Pattern space is split into two 4 KB halves. Each half has two candidate bank registers and a one-bit selector that chooses between them. Software never writes the selectors. The renderer moves them when it fetches the second-plane bytes of two special tile numbers. One tile points its half at the first register and the other points it at the second. Artwork can therefore switch banks part-way through a frame with no processor involvement.

The access that triggers a switch still uses the old selector, and the new choice applies from the next clock onwards. A peek strobe gives the same translation as a read but leaves both selectors alone. This lets debug or preview paths inspect memory without disturbing the display. Addresses at or above 0x2000 are not pattern space. The block flags them and ignores them.

Top module: `tile_bank_latch`

## Requirements
- R1: `pat_hit` is 1 exactly when `vaddr[13]` is 0 (address below 0x2000); when it is 0, `rom_addr` is all zeros.
- R2: For a pattern access, `rom_addr` is {selected bank, `vaddr[11:0]`}. Half 0 (`vaddr[12]`=0) takes `bank_lo_a` when its selector is 0 and `bank_lo_b` when it is 1. Half 1 takes `bank_hi_a` and `bank_hi_b` in the same way.
- R3: After reset, both selectors are 0.
- R4: A clocked read (`rd_en`=1, `peek_en`=0) of a pattern address with `vaddr[3]`=1 updates the selector of half `vaddr[12]`. Tile number `vaddr[11:4]` = 0xFD clears it and 0xFE sets it.
- R5: A read whose `vaddr[3]` is 0, or whose tile is neither 0xFD nor 0xFE, leaves both selectors unchanged.
- R6: The triggering access itself is translated with the selector value from before the update. The new value appears in the translation from the next clock edge.
- R7: A trigger in one half never changes the other half's selector.
- R8: A peek (`peek_en`=1, `rd_en`=0) translates as in R2 and never changes a selector.
- R9: When `rd_en` and `peek_en` are both 1, neither selector changes.
- R10: Accesses with `vaddr[13]`=1 never change a selector, whatever their low bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vaddr | input | 14 | Video address |
| rd_en | input | 1 | Renderer read strobe, may update selectors |
| peek_en | input | 1 | Side-effect-free access strobe |
| bank_lo_a | input | BANK_W | Bank for half 0, selector 0 |
| bank_lo_b | input | BANK_W | Bank for half 0, selector 1 |
| bank_hi_a | input | BANK_W | Bank for half 1, selector 0 |
| bank_hi_b | input | BANK_W | Bank for half 1, selector 1 |
| rom_addr | output | BANK_W+12 | Translated pattern-ROM address |
| pat_hit | output | 1 | Access falls in pattern space |

## Verification
Assertions check the selector rules on every cycle. A peek, an access outside pattern space, or a first-plane fetch leaves the selectors unchanged. A read in one half leaves the other half's selector unchanged. A qualifying 0xFD or 0xFE read gives the expected selector value one cycle later. Only the bench's scenarios show the effect at the ports. It checks the bank that appears in `rom_addr`, including the one-fetch delay between a trigger and its effect, the reset choice, and the handling of simultaneous read and peek. The bench keeps its own selector model and compares against it through directed trigger sequences and random addresses biased toward the special tiles.

// File: rtl/tile_bank_latch.sv
module tile_bank_latch #(
  parameter int BANK_W = 5,
  parameter logic [7:0] TILE_CLR = 8'hFD,
  parameter logic [7:0] TILE_SET = 8'hFE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [13:0]          vaddr,
  input  logic                 rd_en,
  input  logic                 peek_en,
  input  logic [BANK_W-1:0]    bank_lo_a,
  input  logic [BANK_W-1:0]    bank_lo_b,
  input  logic [BANK_W-1:0]    bank_hi_a,
  input  logic [BANK_W-1:0]    bank_hi_b,
  output logic [BANK_W+11:0]   rom_addr,
  output logic                 pat_hit
);
  localparam int ROM_W = BANK_W + 12;

  logic [1:0]        sel_q;
  logic [BANK_W-1:0] bank_sel;

  wire       half = vaddr[12];
  wire [7:0] tile = vaddr[11:4];
  wire       upd  = rd_en & ~peek_en & pat_hit & vaddr[3];

  assign pat_hit = ~vaddr[13];

  always_comb begin
    case ({half, sel_q[half]})
      2'b00:   bank_sel = bank_lo_a;
      2'b01:   bank_sel = bank_lo_b;
      2'b10:   bank_sel = bank_hi_a;
      default: bank_sel = bank_hi_b;
    endcase
  end

  assign rom_addr = pat_hit ? {bank_sel, vaddr[11:0]} : {ROM_W{1'b0}};

  always_ff @(posedge clk) begin
    if (!rst_n)
      sel_q <= 2'b00;
    else if (upd && tile == TILE_CLR)
      sel_q[half] <= 1'b0;
    else if (upd && tile == TILE_SET)
      sel_q[half] <= 1'b1;
  end

  assert_peek_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    peek_en |=> $stable(sel_q));

  assert_far_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vaddr[13] |=> $stable(sel_q));

  assert_plane0_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vaddr[3] |=> $stable(sel_q));

  assert_lo_keeps_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vaddr[12] |=> $stable(sel_q[1]));

  assert_hi_keeps_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vaddr[12] |=> $stable(sel_q[0]));

  assert_clear_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !peek_en && vaddr[13:12] == 2'b00 && vaddr[3] && vaddr[11:4] == TILE_CLR)
      |=> !sel_q[0]);

  assert_set_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !peek_en && vaddr[13:12] == 2'b01 && vaddr[3] && vaddr[11:4] == TILE_SET)
      |=> sel_q[1]);
endmodule

// File: tb/test_tile_bank_latch.sv
module test_tile_bank_latch;
  localparam int BW = 5;
  localparam int RW = BW + 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [13:0]   vaddr = '0;
  logic          rd_en = 1'b0, peek_en = 1'b0;
  logic [BW-1:0] b_la = 5'd3, b_lb = 5'd12, b_ha = 5'd21, b_hb = 5'd30;
  logic [RW-1:0] rom_addr;
  logic          pat_hit;

  int checks = 0;
  int fails  = 0;
  logic [1:0] m_sel = 2'b00;

  always #5 clk = ~clk;

  tile_bank_latch #(.BANK_W(BW)) i_tile_bank_latch (
    .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .rd_en(rd_en), .peek_en(peek_en),
    .bank_lo_a(b_la), .bank_lo_b(b_lb), .bank_hi_a(b_ha), .bank_hi_b(b_hb),
    .rom_addr(rom_addr), .pat_hit(pat_hit));

  function automatic logic [RW-1:0] exp_addr(logic [13:0] a, logic [1:0] s);
    logic [BW-1:0] b;
    if (a[13]) return '0;
    if (!a[12]) b = s[0] ? b_lb : b_la;
    else        b = s[1] ? b_hb : b_ha;
    return {b, a[11:0]};
  endfunction

  function automatic logic [1:0] next_sel(logic [13:0] a, logic r, logic p, logic [1:0] s);
    logic [1:0] n = s;
    if (r && !p && !a[13] && a[3]) begin
      if (a[11:4] == 8'hFD) n[a[12]] = 1'b0;
      else if (a[11:4] == 8'hFE) n[a[12]] = 1'b1;
    end
    return n;
  endfunction

  task automatic step(input logic [13:0] a, input logic r, input logic p, input string tag);
    @(negedge clk);
    vaddr = a; rd_en = r; peek_en = p;
    #1;
    checks++;
    if (pat_hit !== !a[13]) begin
      fails++;
      $display("FAIL R1 pat_hit addr=%h actual=%b expected=%b", a, pat_hit, !a[13]);
    end
    checks++;
    if (rom_addr !== exp_addr(a, m_sel)) begin
      fails++;
      $display("FAIL %s rom_addr addr=%h actual=%h expected=%h", tag, a, rom_addr, exp_addr(a, m_sel));
    end
    @(posedge clk);
    m_sel = next_sel(a, r, p, m_sel);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(14'h0005, 1'b1, 1'b0, "R3");
    step(14'h1005, 1'b1, 1'b0, "R3");
    step(14'h0FE8, 1'b1, 1'b0, "R6");
    step(14'h0123, 1'b1, 1'b0, "R4");
    step(14'h1FE8, 1'b1, 1'b0, "R6");
    step(14'h0123, 1'b1, 1'b0, "R7");
    step(14'h1456, 1'b1, 1'b0, "R4");
    step(14'h0FD0, 1'b1, 1'b0, "R5");
    step(14'h0FC8, 1'b1, 1'b0, "R5");
    step(14'h0100, 1'b1, 1'b0, "R5");
    step(14'h0FD8, 1'b0, 1'b1, "R8");
    step(14'h0100, 1'b1, 1'b0, "R8");
    step(14'h0FD8, 1'b1, 1'b1, "R9");
    step(14'h0100, 1'b1, 1'b0, "R9");
    step(14'h2FD8, 1'b1, 1'b0, "R10");
    step(14'h3FD8, 1'b1, 1'b0, "R10");
    step(14'h0100, 1'b1, 1'b0, "R10");
    step(14'h1100, 1'b1, 1'b0, "R10");
    step(14'h0FD8, 1'b1, 1'b0, "R6");
    step(14'h0100, 1'b1, 1'b0, "R4");
    step(14'h1100, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 3000; i++) begin
      logic [13:0] a = 14'($urandom);
      logic r = ($urandom % 4) != 0;
      logic p = ($urandom % 5) == 0;
      if (($urandom % 3) == 0) begin
        a[11:4] = ($urandom % 2) ? 8'hFD : 8'hFE;
        a[3] = 1'b1;
      end
      if ((i % 97) == 0) begin
        b_la = BW'($urandom); b_lb = BW'($urandom);
        b_ha = BW'($urandom); b_hb = BW'($urandom);
      end
      step(a, r, p, p ? "R8" : "R2");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule